// File: doc/BRIEF.md
# Interrupt Source Routing Controller

This block gathers six event sources from a data-acquisition board and turns them into one request on a shared host interrupt line. The six sources are:

- the ADC FIFO asking for service;
- acquisition done, which is also raised on overflow or overrun;
- DMA terminal count from either of two DMA channels;
- the DAC FIFO asking for service;
- DAC sequence done, which is also raised on underflow;
- a falling edge on the DAC update strobe. That strobe may come from an internal or an external timing source.

Each event latches into its own sticky pending bit. Each bit has its own mask bit in an enable register. Software clears a bit by writing a one to its position in the status register.

The request is the OR of every pending bit whose enable is set. A 3-bit select field in a configuration register steers the request onto one of eight host lines. In index order those lines are IRQ3, IRQ4, IRQ5, IRQ7, IRQ10, IRQ11, IRQ12 and IRQ15. The chosen line is driven high only while the request is active. Every other line, and the chosen line while idle, stays high-impedance so that other devices can share it.

Software reaches the block through a byte-wide register port. A write takes effect on the clock edge. A read is combinational from the read address.

Top module: `irq_router`

## Requirements
- R1: After reset the enable register, the pending bits and the line select are all zero, every `irq_oe` bit is 0, and a read of each address returns 0.
- R2: Pending bit positions are fixed: 0 ADC FIFO service, 1 acquisition done, 2 DMA terminal count (channel A or channel B), 3 DAC FIFO service, 4 DAC sequence done, 5 DAC update falling edge. For sources 0 to 4, an event input that is high at a rising clock edge sets its bit from that edge onward. The bit stays set after the input drops.
- R3: A write to address 1 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left unchanged.
- R4: If a source event and a clear of the same bit fall on the same edge, the bit stays set.
- R5: `dac_upd` is sampled on each edge. When it is high at one edge and low at the next, bit 5 is set at that second edge. A rising transition or a steady level sets nothing.
- R6: The request is the OR of (pending AND enable). While it is active, `irq_oe[sel]` is 1 and every other `irq_oe` bit is 0. While it is inactive, all `irq_oe` bits are 0. At most one bit is ever set. The line drops on the same edge that clears the last enabled pending bit.
- R7: Reads are decoded from `rd_addr`: 0 returns the enable bits in [5:0], 1 returns all six pending bits whatever the enables, 2 returns the line select in [2:0], and 3 returns 0. Unused upper bits read as 0.
- R8: `irq_pin[k]` is driven to 1 when `irq_oe[k]` is 1 and is high-impedance otherwise.
- R9: A write to address 0 replaces the enable bits from that edge onward. Clearing an enable removes its source from the request but leaves its pending bit in place.
- R10: A write to address 2 takes the select from `wr_data[2:0]`, and from that edge onward the request moves to the newly selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_adc_fifo | input | 1 | ADC FIFO needs service |
| ev_acq_end | input | 1 | Acquisition done, overflow or overrun |
| ev_dma_tc_a | input | 1 | DMA channel A terminal count |
| ev_dma_tc_b | input | 1 | DMA channel B terminal count |
| ev_dac_fifo | input | 1 | DAC FIFO needs service |
| ev_dac_seq_end | input | 1 | DAC sequence done or underflow |
| dac_upd | input | 1 | DAC update strobe level (internal or external) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| irq_oe | output | N_LINES | Per-line output enable, at most one bit set |
| irq_pin | output | N_LINES | Tristate host interrupt lines |

## Verification
The in-RTL assertions run on every cycle. They check that at most one line is ever enabled, that a line is enabled exactly when some enabled source is pending, that an event always leaves its bit set on the next cycle even under a clear, that a bit only falls through an explicit clear, and that a rising strobe never counts as an update event. What the bench scenarios alone can show is the observable contract at the ports. That covers the bit-to-source mapping, the exact cycle in which the line rises, drops or moves after a select write, the fact that a masked source stays visible in the status read, and the reset values of the registers.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int N_SRC = 6;

    localparam int SRC_ADC_FIFO = 0;
    localparam int SRC_ACQ_END  = 1;
    localparam int SRC_DMA_TC   = 2;
    localparam int SRC_DAC_FIFO = 3;
    localparam int SRC_DAC_SEQ  = 4;
    localparam int SRC_DAC_UPD  = 5;

    typedef enum logic [1:0] {
        ADDR_ENABLE = 2'd0,
        ADDR_STATUS = 2'd1,
        ADDR_SELECT = 2'd2,
        ADDR_SPARE  = 2'd3
    } reg_addr_e;

    typedef logic [N_SRC-1:0] src_vec_t;

endpackage

// File: rtl/irq_fall_det.sv
module irq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic fall_o
);

    typedef struct packed {
        logic prev;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~sig_i;

    AST_NO_FALL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_i) |-> !fall_o); // R5

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] pend;
    } pd_state_t;

    pd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i])      st_d.pend[i] = 1'b1;
            else if (clr_i[i]) st_d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R4

    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_o) & ~pend_o & ~$past(clr_i)) == '0)); // R3

endmodule

// File: rtl/irq_line_dec.sv
module irq_line_dec #(
    parameter int N_LINES = 8,
    localparam int SEL_W  = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [N_LINES-1:0] oe_o,
    output logic [N_LINES-1:0] pin_o
);

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        assign oe_o[k]  = req_i && (sel_i == SEL_W'(k));
        assign pin_o[k] = oe_o[k] ? 1'b1 : 1'bz;
    end

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oe_o)); // R6

    AST_LINE_IS_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o != '0) |-> oe_o[sel_i]); // R10

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_adc_fifo,
    input  logic               ev_acq_end,
    input  logic               ev_dma_tc_a,
    input  logic               ev_dma_tc_b,
    input  logic               ev_dac_fifo,
    input  logic               ev_dac_seq_end,
    input  logic               dac_upd,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [N_LINES-1:0] irq_oe,
    output logic [N_LINES-1:0] irq_pin
);

    localparam int SEL_W = $clog2(N_LINES);

    typedef struct packed {
        src_vec_t         en;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    src_vec_t  set_vec, clr_vec, pend;
    logic      upd_fall, req;
    reg_addr_e wa, ra;
    logic      unused_wr;

    assign wa        = reg_addr_e'(wr_addr);
    assign ra        = reg_addr_e'(rd_addr);
    assign unused_wr = ^wr_data;

    irq_fall_det u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (dac_upd),
        .fall_o (upd_fall)
    );

    always_comb begin
        set_vec               = '0;
        set_vec[SRC_ADC_FIFO] = ev_adc_fifo;
        set_vec[SRC_ACQ_END]  = ev_acq_end;
        set_vec[SRC_DMA_TC]   = ev_dma_tc_a | ev_dma_tc_b;
        set_vec[SRC_DAC_FIFO] = ev_dac_fifo;
        set_vec[SRC_DAC_SEQ]  = ev_dac_seq_end;
        set_vec[SRC_DAC_UPD]  = upd_fall;
        clr_vec = (wr_en && wa == ADDR_STATUS) ? wr_data[N_SRC-1:0] : '0;
    end

    irq_pending #(.N(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wa == ADDR_ENABLE) cfg_d.en  = wr_data[N_SRC-1:0];
        if (wr_en && wa == ADDR_SELECT) cfg_d.sel = wr_data[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign req = |(pend & cfg_q.en);

    irq_line_dec #(.N_LINES(N_LINES)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .sel_i (cfg_q.sel),
        .oe_o  (irq_oe),
        .pin_o (irq_pin)
    );

    always_comb begin
        case (ra)
            ADDR_ENABLE: rd_data = DATA_W'(cfg_q.en);
            ADDR_STATUS: rd_data = DATA_W'(pend);
            ADDR_SELECT: rd_data = DATA_W'(cfg_q.sel);
            default:     rd_data = '0;
        endcase
    end

    AST_LINE_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe != '0) == ((pend & cfg_q.en) != '0)); // R6

    AST_MASK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wa == ADDR_ENABLE && set_vec == '0) |=> (pend == $past(pend))); // R9

endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;

    localparam int CYC = 8;

    logic       clk = 0, rst_n = 0;
    logic       ev_adc_fifo = 0, ev_acq_end = 0, ev_dma_tc_a = 0, ev_dma_tc_b = 0;
    logic       ev_dac_fifo = 0, ev_dac_seq_end = 0, dac_upd = 0;
    logic       wr_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data, irq_oe, irq_pin;

    int n_chk = 0, n_fail = 0;
    logic [5:0] m_en = 0, m_pend = 0;
    logic [2:0] m_sel = 0;
    logic       m_prev = 0;

    always #(CYC/2) clk = ~clk;

    irq_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_adc_fifo(ev_adc_fifo), .ev_acq_end(ev_acq_end),
        .ev_dma_tc_a(ev_dma_tc_a), .ev_dma_tc_b(ev_dma_tc_b),
        .ev_dac_fifo(ev_dac_fifo), .ev_dac_seq_end(ev_dac_seq_end),
        .dac_upd(dac_upd), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_oe(irq_oe), .irq_pin(irq_pin)
    );

    function automatic logic [7:0] exp_oe(logic [5:0] en, logic [5:0] pd, logic [2:0] sel);
        return ((en & pd) != 0) ? (8'd1 << sel) : 8'd0;
    endfunction

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0:    return {2'b0, m_en};
            2'd1:    return {2'b0, m_pend};
            2'd2:    return {5'b0, m_sel};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [7:0] eo;
        eo = exp_oe(m_en, m_pend, m_sel);
        chk(tag, irq_oe, eo);
        chk(tag, rd_data, exp_rd(rd_addr));
        for (int k = 0; k < 8; k++)
            if (eo[k]) chk("R8", {7'b0, irq_pin[k]}, 8'd1);
    endtask

    task automatic tick(string tag);
        logic [5:0] s, c;
        @(posedge clk);
        s = {m_prev & ~dac_upd, ev_dac_seq_end, ev_dac_fifo,
             ev_dma_tc_a | ev_dma_tc_b, ev_acq_end, ev_adc_fifo};
        c = (wr_en && wr_addr == 2'd1) ? wr_data[5:0] : 6'd0;
        m_pend = (m_pend & ~c) | s;
        if (wr_en && wr_addr == 2'd0) m_en  = wr_data[5:0];
        if (wr_en && wr_addr == 2'd2) m_sel = wr_data[2:0];
        m_prev = dac_upd;
        #2;
        check_all(tag);
        {ev_adc_fifo, ev_acq_end, ev_dma_tc_a, ev_dma_tc_b, ev_dac_fifo, ev_dac_seq_end} = '0;
        wr_en = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    initial begin
        #(CYC * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            chk("R1", rd_data, 8'd0);
        end
        chk("R1", irq_oe, 8'd0);
        rst_n = 1;

        // R2: sticky set, mapping
        wr(2'd0, 8'h3f); tick("R9");
        rd_addr = 2'd1;
        ev_adc_fifo = 1; tick("R2");
        chk("R2", rd_data, 8'h01);
        tick("R2");
        ev_dma_tc_b = 1; tick("R2");
        chk("R2", rd_data, 8'h05);
        // R3: zero writes ignored, one writes clear
        wr(2'd1, 8'h00); tick("R3");
        chk("R3", rd_data, 8'h05);
        wr(2'd1, 8'h05); tick("R3");
        chk("R3", irq_oe, 8'h00);
        // R4: set beats clear
        ev_acq_end = 1; wr(2'd1, 8'h02); tick("R4");
        chk("R4", rd_data, 8'h02);
        wr(2'd1, 8'h02); tick("R4");
        // R5: edge detection
        dac_upd = 1; tick("R5"); tick("R5");
        chk("R5", rd_data, 8'h00);
        dac_upd = 0; tick("R5");
        chk("R5", rd_data, 8'h20);
        tick("R5");
        // R9 / R7: mask keeps pending
        wr(2'd0, 8'h00); tick("R9");
        chk("R9", irq_oe, 8'h00);
        chk("R7", rd_data, 8'h20);
        wr(2'd0, 8'h20); tick("R9");
        chk("R9", irq_oe, 8'h01);
        // R10: line moves
        wr(2'd2, 8'h07); tick("R10");
        chk("R10", irq_oe, 8'h80);
        wr(2'd2, 8'hfb); tick("R10");
        chk("R10", irq_oe, 8'h08);
        rd_addr = 2'd2; #1; chk("R7", rd_data, 8'h03);
        rd_addr = 2'd3; #1; chk("R7", rd_data, 8'h00);
        wr(2'd1, 8'hff); tick("R6");
        chk("R6", irq_oe, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            ev_adc_fifo    = (r[3:0]   == 0);
            ev_acq_end     = (r[7:4]   == 0);
            ev_dma_tc_a    = (r[11:8]  == 0);
            ev_dma_tc_b    = (r[15:12] == 0);
            ev_dac_fifo    = (r[19:16] == 0);
            ev_dac_seq_end = (r[23:20] == 0);
            if (r[26:24] == 0) dac_upd = ~dac_upd;
            rd_addr = r[28:27];
            if (r[31:29] == 0) wr(2'($urandom_range(0, 3)), 8'($urandom));
            tick("R6");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule